// File: doc/BRIEF.md
# Prefix-Length Match Entry

This block is a single entry of a routing table. It holds one 32-bit route prefix together with a mask whose ones run contiguously down from the most significant bit. When a destination key is presented, the entry works out how many leading bits of the key agree with the stored prefix. It counts from the most significant bit and stops at the first disagreement or at the end of the mask. That length is reported as an 11-bit code split into two thermometer fields: one bit per fully matched 8-bit group, and the partial run inside the first group that breaks.

Many entries are placed side by side and searched with the same key in the same cycle. A downstream tree of comparators then picks the longest code. Because the thermometer fields are filled from their low bit upward, comparing two codes as unsigned numbers also compares their match lengths. The code is registered, so it stays stable while the next key is being set up.

Top module: `prefix_len_entry`

## Requirements
- R1: While `rst_n` is low at a clock edge, `res_code` and `res_vld` become zero and the entry is marked unused; a search before any valid write therefore reports zero.
- R2: `res_code[10:7]` is the group field. Bit n (n = 0..3) is set exactly when the top n+1 groups of 8 bits, counted from the MSB, match in every bit under the mask. For example, a 16-bit match gives 0011.
- R3: `res_code[6:0]` is the partial field. Bit k is set exactly when the first k+1 bits, from its MSB, of the first group that is not fully matched all match under the mask. The field is zero when all four groups match. For example, a mismatch at the 5th bit of the third group gives 0001111.
- R4: Only bit positions where the mask is one can count, so the reported length never exceeds the mask length. A full match under a /24 mask gives 0x380, a full match under /32 gives 0x780, and a /0 mask gives 0x000.
- R5: `wr_word` is loaded into the prefix register when `wr_pfx_en` is high and into the mask register when `wr_msk_en` is high. Writing one register leaves the other unchanged.
- R6: `wr_used_en` loads `wr_used` into the entry's in-use flag. While the flag is clear, every search reports a code of zero.
- R7: The code for a search strobed with `srch_en` at one clock edge appears after that edge, with `res_vld` high for exactly that cycle. While `srch_en` is low, `res_code` holds its value and `res_vld` is low.
- R8: When a write and a search happen in the same cycle, the search uses the contents held before the write. The new contents apply from the next search.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| wr_word | input | 32 | Data for prefix or mask write |
| wr_pfx_en | input | 1 | Load `wr_word` into prefix register |
| wr_msk_en | input | 1 | Load `wr_word` into mask register |
| wr_used_en | input | 1 | Load `wr_used` into the in-use flag |
| wr_used | input | 1 | New in-use flag value |
| srch_key | input | 32 | Destination key to compare |
| srch_en | input | 1 | Search strobe |
| res_code | output | 11 | Registered length code: {group field, partial field} |
| res_vld | output | 1 | High in the cycle after a search strobe |

## Verification
The bench builds the entry with its default 32-bit address and 8-bit groups. This gives four groups and a 7-bit partial field, so every group boundary can be reached: 0, 7, 8, 16, 17, 20, 24, 31 and 32 bits. These lengths exercise the cases where the partial field comes from the first group, from a middle group, or from no group at all. Masks of /0, /8, /16, /20, /24 and /32 show the mask cutting the count both on a group boundary and inside a group.

// File: rtl/plm_pkg.sv
// plm_pkg: default geometry shared by the prefix-length match entry.
// Assumes the address width is a whole multiple of the group width.
package plm_pkg;
    localparam int unsigned PLM_ADDR_W = 32;
    localparam int unsigned PLM_GRP_W  = 8;
endpackage

// File: rtl/plm_store.sv
// plm_store: prefix, mask and in-use storage for one entry.
// Each register has its own write enable; the prefix and mask share one
// data word. The outputs are the registered values, so a search in the
// same cycle as a write sees the old contents.
module plm_store #(
    parameter int unsigned ADDR_W = plm_pkg::PLM_ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_word,
    input  logic              wr_pfx_en,
    input  logic              wr_msk_en,
    input  logic              wr_used_en,
    input  logic              wr_used,
    output logic [ADDR_W-1:0] pfx_q,
    output logic [ADDR_W-1:0] msk_q,
    output logic              used_q
);
    // Prefix register: loaded only by its own enable.
    always_ff @(posedge clk) begin
        if (!rst_n)         pfx_q <= '0;
        else if (wr_pfx_en) pfx_q <= wr_word;
    end

    // Mask register: loaded only by its own enable.
    always_ff @(posedge clk) begin
        if (!rst_n)         msk_q <= '0;
        else if (wr_msk_en) msk_q <= wr_word;
    end

    // In-use flag: cleared by reset, set or cleared by a write.
    always_ff @(posedge clk) begin
        if (!rst_n)          used_q <= 1'b0;
        else if (wr_used_en) used_q <= wr_used;
    end
endmodule

// File: rtl/plm_group_cmp.sv
// plm_group_cmp: per-group leading-run detector.
// Input bit GRP_W-1 is the most significant bit of the group. A one means
// the bit matches under the mask. grp_full is set when all bits match.
// run_therm[k] is set when the top k+1 bits all match.
module plm_group_cmp #(
    parameter int unsigned GRP_W = plm_pkg::PLM_GRP_W
) (
    input  logic [GRP_W-1:0] grp_eq,
    output logic             grp_full,
    output logic [GRP_W-2:0] run_therm
);
    // Whole-group agreement.
    assign grp_full = &grp_eq;

    // Leading-run thermometer, one AND tree per length.
    for (genvar k = 0; k < GRP_W - 1; k++) begin : g_run
        assign run_therm[k] = &grp_eq[GRP_W-1 -: k+1];
    end
endmodule

// File: rtl/plm_len_encode.sv
// plm_len_encode: turns the masked bit-agreement vector into the
// two-field length code {group thermometer, partial thermometer}.
// Group 0 is the most significant group. The partial field is taken from
// the first group that is not fully matched, and is zero if there is none.
module plm_len_encode #(
    parameter int unsigned ADDR_W = plm_pkg::PLM_ADDR_W,
    parameter int unsigned GRP_W  = plm_pkg::PLM_GRP_W,
    localparam int unsigned NGRP   = ADDR_W / GRP_W,
    localparam int unsigned FINE_W = GRP_W - 1
) (
    input  logic [ADDR_W-1:0] bit_eq,
    output logic [NGRP-1:0]   grp_therm,
    output logic [FINE_W-1:0] fine_therm
);
    logic [NGRP-1:0]   full;
    logic [FINE_W-1:0] run [NGRP];
    logic [NGRP-1:0]   sel;

    for (genvar g = 0; g < NGRP; g++) begin : g_grp
        plm_group_cmp #(.GRP_W(GRP_W)) u_cmp (
            .grp_eq   (bit_eq[ADDR_W-1-g*GRP_W -: GRP_W]),
            .grp_full (full[g]),
            .run_therm(run[g])
        );
        // Group thermometer: all groups down to this one fully match.
        if (g == 0) begin : g_first
            assign grp_therm[g] = full[g];
            assign sel[g]       = ~full[g];
        end else begin : g_rest
            assign grp_therm[g] = grp_therm[g-1] & full[g];
            assign sel[g]       = grp_therm[g-1] & ~full[g];
        end
    end

    // Partial field: OR of the run codes, gated by the single breaking group.
    always_comb begin
        fine_therm = '0;
        for (int g = 0; g < NGRP; g++) begin
            if (sel[g]) fine_therm = fine_therm | run[g];
        end
    end

    // R3
    always_comb begin
        sel_onehot_chk: assert ($onehot0(sel));
    end
endmodule

// File: rtl/prefix_len_entry.sv
// prefix_len_entry: one routing-table entry that reports, as a registered
// two-field thermometer code, the length of the masked prefix match
// between a search key and its stored prefix. The mask is assumed to be
// contiguous from the MSB. Searches see the contents held before any
// write in the same cycle.
module prefix_len_entry #(
    parameter int unsigned ADDR_W = plm_pkg::PLM_ADDR_W,
    parameter int unsigned GRP_W  = plm_pkg::PLM_GRP_W,
    localparam int unsigned NGRP   = ADDR_W / GRP_W,
    localparam int unsigned FINE_W = GRP_W - 1,
    localparam int unsigned CODE_W = NGRP + FINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] wr_word,
    input  logic              wr_pfx_en,
    input  logic              wr_msk_en,
    input  logic              wr_used_en,
    input  logic              wr_used,
    input  logic [ADDR_W-1:0] srch_key,
    input  logic              srch_en,
    output logic [CODE_W-1:0] res_code,
    output logic              res_vld
);
    logic [ADDR_W-1:0] pfx_q, msk_q;
    logic              used_q;
    logic [ADDR_W-1:0] bit_eq;
    logic [NGRP-1:0]   grp_therm;
    logic [FINE_W-1:0] fine_therm;

    plm_store #(.ADDR_W(ADDR_W)) u_store (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_word   (wr_word),
        .wr_pfx_en (wr_pfx_en),
        .wr_msk_en (wr_msk_en),
        .wr_used_en(wr_used_en),
        .wr_used   (wr_used),
        .pfx_q     (pfx_q),
        .msk_q     (msk_q),
        .used_q    (used_q)
    );

    // Per-bit agreement, counted only where the mask allows it.
    assign bit_eq = ~(srch_key ^ pfx_q) & msk_q;

    plm_len_encode #(.ADDR_W(ADDR_W), .GRP_W(GRP_W)) u_enc (
        .bit_eq    (bit_eq),
        .grp_therm (grp_therm),
        .fine_therm(fine_therm)
    );

    // Result register: captures the gated code on a search strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       res_code <= '0;
        else if (srch_en) res_code <= used_q ? {grp_therm, fine_therm} : '0;
    end

    // Result-valid flag: follows the strobe by one cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) res_vld <= 1'b0;
        else        res_vld <= srch_en;
    end

    // R2
    grp_therm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((res_code[CODE_W-1:FINE_W] + 1'b1) & res_code[CODE_W-1:FINE_W]) == '0);

    // R3
    fine_zero_when_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (&res_code[CODE_W-1:FINE_W]) |-> (res_code[FINE_W-1:0] == '0));

    // R4
    len_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srch_en |=> ($countones(res_code[CODE_W-1:FINE_W]) * GRP_W
                     + $countones(res_code[FINE_W-1:0]))
                    <= $past($countones(msk_q)));

    // R6
    unused_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (srch_en && !used_q) |=> (res_code == '0));

    // R7
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !srch_en |=> ($stable(res_code) && !res_vld));

    // R7
    vld_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srch_en |=> res_vld);
endmodule

// File: tb/tb_prefix_len_entry.sv
`timescale 1ns/1ps
module tb_prefix_len_entry;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] wr_word = '0;
    logic        wr_pfx_en = 1'b0, wr_msk_en = 1'b0, wr_used_en = 1'b0, wr_used = 1'b0;
    logic [31:0] srch_key = '0;
    logic        srch_en = 1'b0;
    logic [10:0] res_code;
    logic        res_vld;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2 clk = ~clk;

    prefix_len_entry dut (
        .clk(clk), .rst_n(rst_n), .wr_word(wr_word),
        .wr_pfx_en(wr_pfx_en), .wr_msk_en(wr_msk_en),
        .wr_used_en(wr_used_en), .wr_used(wr_used),
        .srch_key(srch_key), .srch_en(srch_en),
        .res_code(res_code), .res_vld(res_vld)
    );

    typedef struct packed {
        logic [31:0] pfx;
        logic [31:0] key;
        logic [5:0]  mlen;
        logic [5:0]  elen;
    } vec_t;

    // Stimulus and expected match length.
    localparam vec_t VECS [10] = '{
        '{32'hC0A8_0000, 32'hC0A8_0080, 6'd24, 6'd24},
        '{32'hC0A8_0080, 32'hC0A8_0080, 6'd32, 6'd32},
        '{32'hC0A8_0080, 32'hC0A8_0080, 6'd0,  6'd0 },
        '{32'h0A00_0000, 32'h0B00_0000, 6'd8,  6'd7 },
        '{32'hFFFF_0000, 32'hFFFF_7000, 6'd32, 6'd17},
        '{32'h1234_5678, 32'h1234_5678, 6'd20, 6'd20},
        '{32'h8000_0000, 32'h0000_0000, 6'd32, 6'd0 },
        '{32'hAABB_CCDD, 32'hAABB_CCDC, 6'd32, 6'd31},
        '{32'h1122_3344, 32'h1122_3344, 6'd16, 6'd16},
        '{32'h0102_0300, 32'h0102_0B00, 6'd32, 6'd20}
    };

    function automatic logic [10:0] enc(int len);
        logic [3:0] g = '0;
        logic [6:0] f = '0;
        for (int i = 0; i < len / 8; i++) g[i] = 1'b1;
        for (int i = 0; i < len % 8; i++) f[i] = 1'b1;
        return {g, f};
    endfunction

    function automatic logic [31:0] mask_of(int len);
        logic [31:0] m = '0;
        for (int i = 0; i < len; i++) m[31-i] = 1'b1;
        return m;
    endfunction

    task automatic check(string req, logic [10:0] got, logic [10:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: res_code=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic check_bit(string req, logic got, logic exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s: value=%b expected=%b", req, got, exp);
        end
    endtask

    task automatic wr_pfx(logic [31:0] v);
        @(negedge clk); wr_word = v; wr_pfx_en = 1'b1;
        @(negedge clk); wr_pfx_en = 1'b0;
    endtask

    task automatic wr_msk(logic [31:0] v);
        @(negedge clk); wr_word = v; wr_msk_en = 1'b1;
        @(negedge clk); wr_msk_en = 1'b0;
    endtask

    task automatic wr_use(logic v);
        @(negedge clk); wr_used = v; wr_used_en = 1'b1;
        @(negedge clk); wr_used_en = 1'b0;
    endtask

    // Strobe one search; returns at the negedge after the capturing edge.
    task automatic search(logic [31:0] k);
        @(negedge clk); srch_key = k; srch_en = 1'b1;
        @(negedge clk); srch_en = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        n_chk++; n_bad++;
        $display("FAIL watchdog: value=timeout expected=finish");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        check("R1", res_code, 11'h000);
        check_bit("R1 vld", res_vld, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        wr_pfx(32'h0000_0000); wr_msk(32'hFFFF_FFFF);
        search(32'h0000_0000);
        check("R1 unused after reset", res_code, 11'h000);

        // Vector walk: R2, R3, R4
        wr_use(1'b1);
        for (int i = 0; i < 10; i++) begin
            wr_pfx(VECS[i].pfx);
            wr_msk(mask_of(int'(VECS[i].mlen)));
            search(VECS[i].key);
            check($sformatf("R2/R3/R4 vec%0d", i), res_code, enc(int'(VECS[i].elen)));
            check_bit("R7 vld", res_vld, 1'b1);
        end

        // R4 exact codes for boundary masks
        wr_pfx(32'hC0A8_0100); wr_msk(mask_of(24));
        search(32'hC0A8_01FF);
        check("R4 /24", res_code, 11'h380);
        wr_msk(mask_of(32)); search(32'hC0A8_0100);
        check("R4 /32", res_code, 11'h780);
        wr_msk(32'h0); search(32'hC0A8_0100);
        check("R4 /0", res_code, 11'h000);

        // R3 example: 20 bits -> group 0011, partial 0001111
        wr_pfx(32'h0102_0300); wr_msk(mask_of(32));
        search(32'h0102_0B00);
        check("R3 example", res_code, {4'b0011, 7'b0001111});

        // R5: separate enables
        wr_pfx(32'hAABB_0000); wr_msk(mask_of(16));
        wr_msk(mask_of(8));
        search(32'hAABB_1234);
        check("R5 mask-only write keeps prefix", res_code, enc(8));
        wr_pfx(32'h5500_0000);
        search(32'h55FF_FFFF);
        check("R5 prefix-only write keeps mask", res_code, enc(8));

        // R7: hold while no strobe
        search(32'h5500_0000);
        check("R7 pre", res_code, enc(8));
        @(negedge clk); srch_key = 32'h0000_0000;
        repeat (3) @(negedge clk);
        check("R7 hold", res_code, enc(8));
        check_bit("R7 vld low", res_vld, 1'b0);

        // R8: write and search in the same cycle
        wr_pfx(32'h1122_3344); wr_msk(mask_of(32));
        @(negedge clk);
        wr_word = 32'h1122_0000; wr_pfx_en = 1'b1;
        srch_key = 32'h1122_3344; srch_en = 1'b1;
        @(negedge clk);
        wr_pfx_en = 1'b0; srch_en = 1'b0;
        check("R8 old contents", res_code, enc(32));
        search(32'h1122_3344);
        check("R8 new contents", res_code, enc(18));

        // R6: unused entry reports zero, then reuse restores
        wr_use(1'b0);
        search(32'h1122_0000);
        check("R6 unused", res_code, 11'h000);
        wr_use(1'b1);
        search(32'h1122_0000);
        check("R6 reused", res_code, enc(32));

        // R1: reset mid-run clears code and in-use flag
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk);
        check("R1 mid reset", res_code, 11'h000);
        rst_n = 1'b1;
        wr_pfx(32'h1122_0000); wr_msk(mask_of(32));
        search(32'h1122_0000);
        check("R1 flag cleared", res_code, 11'h000);

        finish_run();
    end
endmodule